// File: doc/BRIEF.md
# Tunable Second-Order Noise-Shaping Requantizer

This block shortens a signed sine amplitude sample of AW+EW bits to a signed sample of AW bits. It does not simply drop the low bits. It keeps the error made by each shortening and subtracts a filtered copy of the last two errors from the following samples. The quantization noise then reaches the output through the response 1 + b1·z^-1 + b2·z^-2. Both coefficients are run-time inputs, so the two zeros of that response can be placed near the frequency currently being synthesized. The remaining noise then lies away from the carrier, where an analog band-pass filter can remove it.

The supported coefficients are b1 ∈ {0, +1, -1, -2} and b2 ∈ {0, +1}. Each product is built from a negation or a one-bit shift, so no multiplier is used. Typical coefficient pairs are:

- b1 = -2, b2 = +1: a double zero at dc.
- b1 = 0, b2 = +1: zeros at a quarter of the sample rate.
- b1 = +1, b2 = +1: zeros at a third of the sample rate.
- b1 = -1, b2 = +1: zeros at a sixth of the sample rate.

The upstream stage is expected to scale its samples so that the input plus the largest feedback never leaves the output range. The output saturates if that rule is broken.

Top module: `ef2_requant`

## Requirements
- R1: The output is registered with one cycle of latency. `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R2: For each valid sample x, the corrected value is v = x + b1·e1 + b2·e2, where e1 is the newest stored error and e2 the older one.
  - The output is y = floor(v / 2^EW).
  - The new error is e = y·2^EW − v. It is always zero or negative, and its magnitude is the unsigned value of the EW low bits of v.
- R3: `b1_sel` encodes b1 as follows: 2'b00 = 0, 2'b01 = +1, 2'b10 = -1, 2'b11 = -2.
- R4: `b2_sel` encodes b2 as follows: 0 = 0, 1 = +1.
- R5: The stored errors change only on valid cycles, when the new error becomes e1 and the previous e1 becomes e2. A cycle with `in_valid` low and unchanged coefficients leaves both errors unchanged.
- R6: Any cycle whose coefficient inputs differ from those of the previous cycle clears both stored errors. A sample presented in that cycle uses the new coefficients with both errors taken as zero.
- R7: If floor(v / 2^EW) lies outside the signed AW-bit range, the output saturates to -2^(AW-1) or 2^(AW-1)-1. The stored error is still taken from the unsaturated v.
- R8: While `in_valid` is low, `y_out` keeps its last value.
- R9: After reset, `y_out` is 0 and `out_valid` is 0. The stored errors are zero, and the remembered coefficients are b1_sel = 2'b00 and b2_sel = 0.
- R10: With b1 = -2 and b2 = +1 and a constant input x, the sum of y·2^EW over any 64 consecutive valid samples after the coefficient change differs from 64·x by at most 4·2^EW. This is the effect of the double zero at dc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `x_in` |
| x_in | input | AW+EW | Signed wide amplitude sample |
| b1_sel | input | 2 | First feedback coefficient select (R3 encoding) |
| b2_sel | input | 1 | Second feedback coefficient select (R4 encoding) |
| out_valid | output | 1 | High one cycle after a valid input |
| y_out | output | AW | Signed shortened amplitude sample |

## Verification
A sample driven before a rising edge shows its output and `out_valid` after that same edge. The stored errors it produces first affect the sample accepted at the next edge. The bench therefore drives inputs at the falling edge and checks the outputs of the previous sample at the following falling edge. At that point exactly one register stage separates stimulus from result. The bench's model of the two stored errors advances at the same point, which keeps the history clearing on a coefficient change aligned with the cycle in which it happens.

// File: rtl/ef2_pkg.sv
package ef2_pkg;

    typedef enum logic [1:0] {
        B1_ZERO   = 2'b00,
        B1_PLUS1  = 2'b01,
        B1_MINUS1 = 2'b10,
        B1_MINUS2 = 2'b11
    } b1_sel_e;

    typedef enum logic [0:0] {
        TAP_FIRST  = 1'b0,
        TAP_SECOND = 1'b1
    } tap_kind_e;

endpackage

// File: rtl/ef2_tap.sv
// One feedback tap: produces b*e for a stored error e = -r, where r is the
// unsigned residue kept in the history. Only negation and a one-bit shift.
module ef2_tap
    import ef2_pkg::*;
#(
    parameter int        EW   = 6,
    parameter int        SW   = 17,
    parameter tap_kind_e KIND = TAP_FIRST
) (
    input  logic [1:0]          sel,
    input  logic [EW-1:0]       resid,
    output logic signed [SW-1:0] term
);
    localparam int PADW = SW - EW;

    logic signed [SW-1:0] r_ext;
    logic signed [SW-1:0] r_dbl;

    always_comb begin
        r_ext = $signed({{PADW{1'b0}}, resid});
        r_dbl = $signed({{(PADW-1){1'b0}}, resid, 1'b0});
    end

    generate
        if (KIND == TAP_FIRST) begin : g_first
            always_comb begin
                unique case (b1_sel_e'(sel))
                    B1_ZERO:   term = '0;
                    B1_PLUS1:  term = -r_ext;
                    B1_MINUS1: term = r_ext;
                    B1_MINUS2: term = r_dbl;
                    default:   term = '0;
                endcase
            end
        end else begin : g_second
            logic unused_hi;
            always_comb begin
                unused_hi = sel[1];
                term      = sel[0] ? -r_ext : '0;
            end
        end
    endgenerate

endmodule

// File: rtl/ef2_quant.sv
// Splits the corrected value into a saturated AW-bit word and an EW-bit residue.
module ef2_quant #(
    parameter int AW = 8,
    parameter int EW = 6,
    parameter int SW = 17
) (
    input  logic signed [SW-1:0] corr,
    output logic signed [AW-1:0] y,
    output logic [EW-1:0]        resid,
    output logic                 sat
);
    localparam int QW = SW - EW;
    localparam logic signed [AW-1:0] YMAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] YMIN = {1'b1, {(AW-1){1'b0}}};

    logic [QW-1:0] q;
    logic          all_one;
    logic          all_zero;

    always_comb begin
        q        = corr[SW-1:EW];
        resid    = corr[EW-1:0];
        all_one  = &q[QW-1:AW-1];
        all_zero = ~|q[QW-1:AW-1];
        sat      = !(all_one || all_zero);
        if (!sat)            y = $signed(q[AW-1:0]);
        else if (q[QW-1])    y = YMIN;
        else                 y = YMAX;
    end

endmodule

// File: rtl/ef2_requant.sv
module ef2_requant
    import ef2_pkg::*;
#(
    parameter int AW = 8,
    parameter int EW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [AW+EW-1:0]     x_in,
    input  logic [1:0]           b1_sel,
    input  logic                 b2_sel,
    output logic                 out_valid,
    output logic [AW-1:0]        y_out
);
    localparam int IW = AW + EW;
    localparam int SW = IW + 3;

    typedef struct packed {
        logic [AW-1:0] y;
        logic          vld;
        logic [EW-1:0] r1;
        logic [EW-1:0] r2;
        logic [1:0]    b1;
        logic          b2;
    } st_t;

    st_t st_d, st_q;

    logic                  coef_chg;
    logic [EW-1:0]         h1, h2;
    logic signed [SW-1:0]  t1, t2, x_ext, corr;
    logic signed [AW-1:0]  yq;
    logic [EW-1:0]         rnew;
    logic                  sat;

    always_comb begin
        coef_chg = (b1_sel != st_q.b1) || (b2_sel != st_q.b2);
        h1       = coef_chg ? '0 : st_q.r1;
        h2       = coef_chg ? '0 : st_q.r2;
    end

    ef2_tap #(.EW(EW), .SW(SW), .KIND(TAP_FIRST)) u_tap1 (
        .sel   (b1_sel),
        .resid (h1),
        .term  (t1)
    );

    ef2_tap #(.EW(EW), .SW(SW), .KIND(TAP_SECOND)) u_tap2 (
        .sel   ({1'b0, b2_sel}),
        .resid (h2),
        .term  (t2)
    );

    always_comb begin
        x_ext = $signed({{(SW-IW){x_in[IW-1]}}, x_in});
        corr  = x_ext + t1 + t2;
    end

    ef2_quant #(.AW(AW), .EW(EW), .SW(SW)) u_quant (
        .corr  (corr),
        .y     (yq),
        .resid (rnew),
        .sat   (sat)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.b1  = b1_sel;
        st_d.b2  = b2_sel;
        if (coef_chg) begin
            st_d.r1 = '0;
            st_d.r2 = '0;
        end
        if (in_valid) begin
            st_d.y  = yq;
            st_d.r1 = rnew;
            st_d.r2 = h1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign y_out     = st_q.y;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(y_out)); // R8
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !coef_chg) |=> (st_q.r2 == $past(st_q.r1))); // R5
    AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !coef_chg) |=> ($stable(st_q.r1) && $stable(st_q.r2))); // R5
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_chg && !in_valid) |=> (st_q.r1 == '0 && st_q.r2 == '0)); // R6
    AST_CLEAR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_chg && in_valid) |=> (st_q.r2 == '0)); // R6
    AST_SAT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat) |=> (y_out == {y_out[AW-1], {(AW-1){~y_out[AW-1]}}})); // R7

endmodule

// File: tb/tb_ef2_requant.sv
module tb_ef2_requant;
    localparam int AW = 8;
    localparam int EW = 6;
    localparam int IW = AW + EW;
    localparam int SC = 1 << EW;
    localparam int YMAX = (1 << (AW-1)) - 1;
    localparam int YMIN = -(1 << (AW-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IW-1:0] x_in = '0;
    logic [1:0] b1_sel = 2'b00;
    logic b2_sel = 1'b0;
    logic out_valid;
    logic [AW-1:0] y_out;

    always #2 clk = ~clk;

    ef2_requant #(.AW(AW), .EW(EW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
        .b1_sel(b1_sel), .b2_sel(b2_sel), .out_valid(out_valid), .y_out(y_out)
    );

    int checks = 0;
    int fails = 0;
    int mr1 = 0, mr2 = 0, exp_y = 0;
    logic [1:0] mb1 = 2'b00;
    logic mb2 = 1'b0;
    logic exp_v = 1'b0;
    string exp_tag = "R9";
    logic acc_on = 1'b0, exp_acc = 1'b0;
    longint acc_sum = 0;
    int acc_n = 0;

    function automatic int b1_val(input logic [1:0] s);
        case (s)
            2'b00: return 0;
            2'b01: return 1;
            2'b10: return -1;
            default: return -2;
        endcase
    endfunction

    function automatic int sat_y(input int q);
        if (q > YMAX) return YMAX;
        if (q < YMIN) return YMIN;
        return q;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int x, input logic [1:0] b1,
                         input logic b2, input string tag);
        int h1, h2, corr, q;
        logic chg;
        @(negedge clk);
        check("R1", int'(out_valid), int'(exp_v));
        check(exp_v ? exp_tag : "R8", int'($signed(y_out)), exp_y);
        if (exp_v && exp_acc) begin
            acc_sum += longint'($signed(y_out)) * SC;
            acc_n++;
        end
        in_valid = v; x_in = IW'(x); b1_sel = b1; b2_sel = b2;
        chg = (b1 != mb1) || (b2 != mb2);
        h1 = chg ? 0 : mr1;
        h2 = chg ? 0 : mr2;
        if (chg) begin mr1 = 0; mr2 = 0; end
        mb1 = b1; mb2 = b2;
        exp_v = v;
        exp_acc = acc_on;
        if (v) begin
            exp_tag = tag;
            corr = x + b1_val(b1) * (-h1) + int'(b2) * (-h2);
            q = corr >>> EW;
            exp_y = sat_y(q);
            mr2 = h1;
            mr1 = corr - q * SC;
        end
    endtask

    function automatic int rnd_x(input int lim);
        return int'($urandom_range(2 * lim)) - lim;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R9", int'(out_valid), 0);
        check("R9", int'(y_out), 0);
        rst_n = 1'b1;
        // R9: first sample after reset uses b=(0,0) with empty history
        drive(1'b1, 1000, 2'b00, 1'b0, "R9");
        drive(1'b1, -1000, 2'b00, 1'b0, "R9");
        // R2 R3 R4 R5: sweep every coefficient pair with random stimulus
        for (int b1 = 0; b1 < 4; b1++) begin
            for (int b2 = 0; b2 < 2; b2++) begin
                for (int k = 0; k < 150; k++)
                    drive(($urandom_range(3) != 0), rnd_x(8000), 2'(b1), 1'(b2), "R2,R3,R4,R5");
            end
        end
        // R5 R8: idle gaps keep history and output
        for (int k = 0; k < 40; k++)
            drive((k % 5 == 0), rnd_x(8000), 2'b11, 1'b1, "R5,R8");
        // R6: coefficient changes with and without a sample
        for (int k = 0; k < 60; k++)
            drive(($urandom_range(1) != 0), rnd_x(8000), 2'($urandom_range(3)),
                  1'($urandom_range(1)), "R6");
        drive(1'b1, 3000, 2'b11, 1'b1, "R6");
        drive(1'b1, 3001, 2'b11, 1'b1, "R6");
        drive(1'b0, 0, 2'b01, 1'b0, "R6");
        drive(1'b1, 3002, 2'b01, 1'b0, "R6");
        // R7: full-scale inputs with growing feedback
        drive(1'b1, 63, 2'b11, 1'b0, "R7");
        drive(1'b1, 8191, 2'b11, 1'b0, "R7");
        drive(1'b1, -8192, 2'b01, 1'b1, "R7");
        for (int k = 0; k < 100; k++)
            drive(1'b1, rnd_x(8191), 2'b11, 1'b1, "R7");
        // R10: double zero at dc, constant input
        drive(1'b0, 0, 2'b00, 1'b0, "R10");
        acc_on = 1'b1;
        for (int k = 0; k < 64; k++) drive(1'b1, 1000, 2'b11, 1'b1, "R10");
        acc_on = 1'b0;
        drive(1'b0, 0, 2'b11, 1'b1, "R10");
        check("R10", acc_n, 64);
        check("R10", int'((acc_sum - 64 * 1000 > 4 * SC) || (64 * 1000 - acc_sum > 4 * SC)), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule